// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a processor core and decides, cycle by cycle, whether normal execution must stop and hand control to a background debugger. It watches three strobes: an acknowledged breakpoint request (external or from a peripheral, which share one input), a decoded background opcode, and a second bus fault that arrives before any bus cycle completes successfully. A debug-enable input selects what happens next. With debug allowed, the core is frozen, the serial debug port is switched on one cycle later, and a 32-bit scratch register is loaded with a word that tells the debugger which source caused the stop. With debug not allowed, each source falls back to its own action: a breakpoint exception, an illegal-instruction trap, or a permanent halt.

The scratch word is protected until the debugger has issued its first read-system-register command. Only after that may later debugger writes replace it. A resume strobe from the command logic releases the core. A double fault taken during the initial stack-pointer/program-counter fetch forces the visible program counter to all ones. This is the only way that an odd value can appear there.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: When `bkpt_req` is high in the running state and `dbg_en` is 1, `freeze` is high and `atemp` is 0x00000000 on the next cycle, and `bkpt_ack_cyc` stays 0. When `dbg_en` is 0, `bkpt_exc` and `bkpt_ack_cyc` pulse high for exactly one cycle and `exc_vector` reads 0x0C during that pulse (0x00 otherwise).
- R2: When `opcode_valid` is high with `opcode` equal to 0x4AFA and `dbg_en` is 1, the block enters debug mode with `atemp` = 0x00000001. When `dbg_en` is 0, `illegal_trap` pulses for one cycle. Any other opcode value has no effect.
- R3: A second `bus_fault` with no `bus_done` since the first is a double fault. With `dbg_en` 1 it enters debug mode with `atemp` = {`ssw`, 0xFFFF}. With `dbg_en` 0 it sets `halted`, which stays high until reset, and the block then ignores every source.
- R4: A `bus_done` strobe (without `bus_fault` in the same cycle) clears a pending single fault, so a later single fault does not form a double fault.
- R5: `freeze` rises on the cycle after the winning source, and `ser_en` rises exactly one cycle after `freeze`. `ser_en` is never high without `freeze`.
- R6: When several sources are valid in the same cycle, the double fault wins over the breakpoint, and the breakpoint wins over the background opcode. Only the winner's code is loaded or the winner's fallback taken.
- R7: `pc_out` equals `pc_in` with bit 0 cleared. The exception is a double fault taken while `reset_fetch` is high: from the next cycle until a resume, `pc_out` is 0xFFFFFFFF.
- R8: While frozen, `atemp` holds its entry value until a `rsreg_cmd` is seen with `ser_en` high. That command sets `source_read`. `dbg_wr` replaces `atemp` with `dbg_wdata` only once `source_read` is already set.
- R9: A `resume` pulse while frozen clears `freeze`, `ser_en` and `source_read` on the next cycle. Sources that arrive while frozen are ignored: they cause no exception, trap or change of `atemp`.
- R10: After reset, `freeze`, `ser_en`, `source_read`, `bkpt_exc`, `illegal_trap`, `halted` and `atemp` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 1 | Debug mode allowed |
| bkpt_req | input | 1 | Acknowledged breakpoint request strobe |
| opcode_valid | input | 1 | Decoded opcode is valid this cycle |
| opcode | input | 16 | Decoded opcode |
| bus_fault | input | 1 | Bus cycle ended in a fault |
| bus_done | input | 1 | Bus cycle completed successfully |
| reset_fetch | input | 1 | Initial SP/PC fetch after reset in progress |
| ssw | input | 16 | Special status word of the faulting cycle |
| pc_in | input | 32 | Core program counter |
| rsreg_cmd | input | 1 | Read-system-register command strobe |
| dbg_wr | input | 1 | Debugger write strobe for the scratch register |
| dbg_wdata | input | 32 | Debugger write data |
| resume | input | 1 | Leave debug mode |
| freeze | output | 1 | Core execution suspended |
| ser_en | output | 1 | Serial debug port enabled |
| atemp | output | 32 | Scratch register carrying the entry-source code |
| source_read | output | 1 | Entry code has been read once |
| bkpt_exc | output | 1 | Breakpoint exception pulse |
| exc_vector | output | 8 | Exception vector number during `bkpt_exc` |
| bkpt_ack_cyc | output | 1 | Breakpoint-acknowledge bus cycle request |
| illegal_trap | output | 1 | Illegal-instruction trap pulse |
| halted | output | 1 | Core halted by a double fault |
| pc_out | output | 32 | Program counter seen outside the core |

## Verification
Every cycle, the checker confirms four things: the serial port is never enabled without freeze, and it is enabled only after a frozen cycle; the scratch word cannot move between entry and the first read; the fallback pulses are mutually exclusive and absent while frozen; and an odd program counter is always the all-ones marker. The bench is needed for the behaviour that depends on history and choice: the exact code word of each source, the priority among simultaneous sources, the fault pairing with and without an intervening completion, and the sticky halt. It sweeps every combination of the three sources under both settings of the enable.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_FRZ  = 2'd1,
        ST_DBG  = 2'd2,
        ST_HALT = 2'd3
    } dbg_state_e;

    localparam logic [15:0] BGND_OPCODE = 16'h4AFA;
    localparam logic [7:0]  BKPT_VECTOR = 8'h0C;

    typedef struct packed {
        dbg_state_e  st;
        logic [31:0] atemp;
        logic        src_rd;
        logic        bkpt_exc;
        logic        bkpt_cyc;
        logic        ill_trap;
        logic        pc_force;
    } ctl_s;

endpackage

// File: rtl/dbl_fault_det.sv
module dbl_fault_det (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic bus_fault,
    input  logic bus_done,
    output logic dbl
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        dbl    = arm & bus_fault & pend_q;
        if (!arm) begin
            pend_d = 1'b0;
        end else if (bus_fault) begin
            // a second fault is consumed by the double-fault event
            pend_d = ~pend_q;
        end else if (bus_done) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/src_pick.sv
module src_pick #(
    parameter int DATA_W = 32
) (
    input  logic                  dbf,
    input  logic                  bkpt,
    input  logic                  bgnd,
    input  logic [DATA_W/2-1:0]   ssw,
    output logic                  pick_dbf,
    output logic                  pick_bkpt,
    output logic                  pick_bgnd,
    output logic [DATA_W-1:0]     code
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        pick_dbf  = dbf;
        pick_bkpt = bkpt & ~dbf;
        pick_bgnd = bgnd & ~dbf & ~bkpt;
        code      = '0;
        if (pick_dbf)       code = {ssw, {HALF{1'b1}}};
        else if (pick_bgnd) code = {{(DATA_W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OP_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dbg_en,
    input  logic                bkpt_req,
    input  logic                opcode_valid,
    input  logic [OP_W-1:0]     opcode,
    input  logic                bus_fault,
    input  logic                bus_done,
    input  logic                reset_fetch,
    input  logic [DATA_W/2-1:0] ssw,
    input  logic [DATA_W-1:0]   pc_in,
    input  logic                rsreg_cmd,
    input  logic                dbg_wr,
    input  logic [DATA_W-1:0]   dbg_wdata,
    input  logic                resume,
    output logic                freeze,
    output logic                ser_en,
    output logic [DATA_W-1:0]   atemp,
    output logic                source_read,
    output logic                bkpt_exc,
    output logic [7:0]          exc_vector,
    output logic                bkpt_ack_cyc,
    output logic                illegal_trap,
    output logic                halted,
    output logic [DATA_W-1:0]   pc_out
);
    ctl_s c_d, c_q;

    logic running, bgnd_hit, bkpt_hit, dbf_hit;
    logic pick_dbf, pick_bkpt, pick_bgnd, any_src;
    logic [DATA_W-1:0] code;

    assign running  = (c_q.st == ST_RUN);
    assign bgnd_hit = running & opcode_valid & (opcode == OP_W'(BGND_OPCODE));
    assign bkpt_hit = running & bkpt_req;

    dbl_fault_det u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (running),
        .bus_fault (bus_fault),
        .bus_done  (bus_done),
        .dbl       (dbf_hit)
    );

    src_pick #(.DATA_W(DATA_W)) u_pick (
        .dbf       (dbf_hit),
        .bkpt      (bkpt_hit),
        .bgnd      (bgnd_hit),
        .ssw       (ssw),
        .pick_dbf  (pick_dbf),
        .pick_bkpt (pick_bkpt),
        .pick_bgnd (pick_bgnd),
        .code      (code)
    );

    assign any_src = pick_dbf | pick_bkpt | pick_bgnd;

    always_comb begin
        c_d          = c_q;
        c_d.bkpt_exc = 1'b0;
        c_d.bkpt_cyc = 1'b0;
        c_d.ill_trap = 1'b0;
        case (c_q.st)
            ST_RUN: begin
                if (pick_dbf && reset_fetch) c_d.pc_force = 1'b1;
                if (any_src) begin
                    if (dbg_en) begin
                        c_d.st     = ST_FRZ;
                        c_d.atemp  = DATA_W'(code);
                        c_d.src_rd = 1'b0;
                    end else if (pick_dbf) begin
                        c_d.st = ST_HALT;
                    end else if (pick_bkpt) begin
                        c_d.bkpt_exc = 1'b1;
                        c_d.bkpt_cyc = 1'b1;
                    end else begin
                        c_d.ill_trap = 1'b1;
                    end
                end
            end
            ST_FRZ: begin
                // freeze first; the serial port follows a cycle later
                c_d.st = ST_DBG;
                if (resume) begin
                    c_d.st       = ST_RUN;
                    c_d.pc_force = 1'b0;
                end
            end
            ST_DBG: begin
                if (rsreg_cmd)            c_d.src_rd = 1'b1;
                if (dbg_wr && c_q.src_rd) c_d.atemp  = dbg_wdata;
                if (resume) begin
                    c_d.st       = ST_RUN;
                    c_d.src_rd   = 1'b0;
                    c_d.pc_force = 1'b0;
                end
            end
            default: begin
                c_d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_RUN, atemp: '0, src_rd: 1'b0, bkpt_exc: 1'b0,
                     bkpt_cyc: 1'b0, ill_trap: 1'b0, pc_force: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign freeze       = (c_q.st == ST_FRZ) | (c_q.st == ST_DBG);
    assign ser_en       = (c_q.st == ST_DBG);
    assign atemp        = c_q.atemp;
    assign source_read  = c_q.src_rd;
    assign bkpt_exc     = c_q.bkpt_exc;
    assign exc_vector   = c_q.bkpt_exc ? BKPT_VECTOR : 8'h00;
    assign bkpt_ack_cyc = c_q.bkpt_cyc;
    assign illegal_trap = c_q.ill_trap;
    assign halted       = (c_q.st == ST_HALT);
    assign pc_out       = c_q.pc_force ? {DATA_W{1'b1}} : {pc_in[DATA_W-1:1], 1'b0};

endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              freeze,
    input logic              ser_en,
    input logic [DATA_W-1:0] atemp,
    input logic              source_read,
    input logic              bkpt_exc,
    input logic              bkpt_ack_cyc,
    input logic              illegal_trap,
    input logic              halted,
    input logic [DATA_W-1:0] pc_out
);
    a_r5_ser_needs_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> freeze);

    a_r5_ser_after_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_en) |-> $past(freeze));

    a_r8_atemp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && $past(freeze) && !$past(source_read)) |-> $stable(atemp));

    a_r9_no_fallback_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !(bkpt_exc || illegal_trap || halted));

    a_r6_one_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bkpt_exc, illegal_trap}));

    a_r1_ack_only_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_ack_cyc |-> bkpt_exc);

    a_r7_odd_pc_marker: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[0] |-> (pc_out == {DATA_W{1'b1}}));

    a_r3_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halted) |-> halted);
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .freeze       (freeze),
    .ser_en       (ser_en),
    .atemp        (atemp),
    .source_read  (source_read),
    .bkpt_exc     (bkpt_exc),
    .bkpt_ack_cyc (bkpt_ack_cyc),
    .illegal_trap (illegal_trap),
    .halted       (halted),
    .pc_out       (pc_out)
);

// File: tb/test_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module test_dbg_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_en = 1'b0, bkpt_req = 1'b0, opcode_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic        bus_fault = 1'b0, bus_done = 1'b0, reset_fetch = 1'b0;
    logic [15:0] ssw = '0;
    logic [31:0] pc_in = '0;
    logic        rsreg_cmd = 1'b0, dbg_wr = 1'b0, resume = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic        freeze, ser_en, source_read, bkpt_exc, bkpt_ack_cyc, illegal_trap, halted;
    logic [31:0] atemp, pc_out;
    logic [7:0]  exc_vector;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbg_entry_ctrl i_dbg_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .bkpt_req(bkpt_req),
        .opcode_valid(opcode_valid), .opcode(opcode), .bus_fault(bus_fault),
        .bus_done(bus_done), .reset_fetch(reset_fetch), .ssw(ssw), .pc_in(pc_in),
        .rsreg_cmd(rsreg_cmd), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .resume(resume),
        .freeze(freeze), .ser_en(ser_en), .atemp(atemp), .source_read(source_read),
        .bkpt_exc(bkpt_exc), .exc_vector(exc_vector), .bkpt_ack_cyc(bkpt_ack_cyc),
        .illegal_trap(illegal_trap), .halted(halted), .pc_out(pc_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bkpt_req = 0; opcode_valid = 0; opcode = '0; bus_fault = 0; bus_done = 0;
        rsreg_cmd = 0; dbg_wr = 0; resume = 0;
    endtask

    // one cycle: inputs set at negedge, results seen at the following negedge
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        reset_fetch = 0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic run_case(input bit en, input int mask);
        logic [31:0] exp_code;
        logic [15:0] s;
        s = 16'h1000 + 16'(mask * 16'h0111) + 16'(en);
        do_reset();
        dbg_en = en;
        ssw = s;
        if (mask[2]) begin
            bus_fault = 1;
            step();
        end
        bkpt_req = mask[0];
        opcode_valid = mask[1];
        opcode = 16'h4AFA;
        bus_fault = mask[2];
        step();
        if (mask[2])      exp_code = {s, 16'hFFFF};
        else if (mask[0]) exp_code = 32'h0;
        else              exp_code = 32'h1;
        if (en) begin
            chk("R5 freeze after source", {31'b0, freeze}, 1);
            chk("R5 serial not yet on", {31'b0, ser_en}, 0);
            chk("R6/R1/R2/R3 entry code", atemp, exp_code);
            chk("R1 no ack cycle", {31'b0, bkpt_ack_cyc}, 0);
            chk("R1 no exception", {31'b0, bkpt_exc | illegal_trap | halted}, 0);
            step();
            chk("R5 serial on", {31'b0, ser_en & freeze}, 1);
            dbg_wr = 1; dbg_wdata = 32'hDEAD0000 + 32'(mask);
            step();
            chk("R8 write before read ignored", atemp, exp_code);
            bkpt_req = 1; opcode_valid = 1; bus_fault = 1;
            step();
            chk("R9 frozen source ignored", atemp, exp_code);
            chk("R9 frozen no fallback", {31'b0, bkpt_exc | illegal_trap | halted}, 0);
            rsreg_cmd = 1;
            step();
            chk("R8 source_read set", {31'b0, source_read}, 1);
            dbg_wr = 1; dbg_wdata = 32'hBEEF0000 + 32'(mask);
            step();
            chk("R8 write after read", atemp, 32'hBEEF0000 + 32'(mask));
            resume = 1;
            step();
            chk("R9 resume", {29'b0, freeze, ser_en, source_read}, 0);
        end else begin
            chk("R6 no freeze when disabled", {31'b0, freeze}, 0);
            if (mask[2]) begin
                chk("R3 halted", {31'b0, halted}, 1);
                chk("R6 dbf wins", {31'b0, bkpt_exc | illegal_trap}, 0);
                bkpt_req = 1;
                step();
                step();
                chk("R3 halt sticky, sources ignored", {30'b0, halted, bkpt_exc}, 2);
            end else if (mask[0]) begin
                chk("R1 exception pulse", {29'b0, bkpt_exc, bkpt_ack_cyc, illegal_trap}, 3'b110);
                chk("R1 vector", {24'b0, exc_vector}, 32'h0C);
                step();
                chk("R1 single pulse", {30'b0, bkpt_exc, bkpt_ack_cyc}, 0);
                chk("R1 vector idle", {24'b0, exc_vector}, 0);
            end else begin
                chk("R2 trap pulse", {30'b0, illegal_trap, bkpt_exc}, 2);
                step();
                chk("R2 single pulse", {31'b0, illegal_trap}, 0);
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset outputs", {26'b0, freeze, ser_en, source_read, bkpt_exc, illegal_trap, halted}, 0);
        chk("R10 reset atemp", atemp, 0);
        rst_n = 1;

        for (int en = 0; en < 2; en++)
            for (int m = 1; m < 8; m++)
                run_case(en[0], m);

        // R2: other opcodes have no effect
        do_reset();
        for (int en = 0; en < 2; en++) begin
            dbg_en = en[0];
            opcode_valid = 1; opcode = 16'h4AFB - 16'(en * 2);
            step();
            chk("R2 other opcode ignored", {30'b0, freeze, illegal_trap}, 0);
        end

        // R4: completion between faults prevents a double fault
        for (int en = 0; en < 2; en++) begin
            do_reset();
            dbg_en = en[0];
            bus_fault = 1; step();
            bus_done = 1;  step();
            bus_fault = 1; step();
            chk("R4 no double after completion", {30'b0, freeze, halted}, 0);
            bus_fault = 1; step();
            chk("R3 double after two faults", {30'b0, freeze, halted}, en ? 2 : 1);
        end

        // R7: program counter masking and forcing
        do_reset();
        dbg_en = 1;
        for (int k = 0; k < 4; k++) begin
            pc_in = 32'h00012345 + 32'(k * 32'h1111);
            step();
            chk("R7 pc even", pc_out, pc_in & 32'hFFFFFFFE);
        end
        reset_fetch = 1;
        bus_fault = 1; step();
        bus_fault = 1; step();
        chk("R7 pc forced", pc_out, 32'hFFFFFFFF);
        reset_fetch = 0;
        step();
        chk("R7 pc still forced", pc_out, 32'hFFFFFFFF);
        resume = 1; step();
        chk("R7 pc released", pc_out, pc_in & 32'hFFFFFFFE);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule